// File: doc/BRIEF.md
# Counterflow Substitution Shift Chain

This block is a fixed-length shift chain of 8-bit words that always stays full. Each step strobe pushes one word in at the head, and the word at the tail leaves. Next to it runs a second chain of the same length that moves the other way. It carries substitution tokens, each made of a match value, a replacement value and a valid bit. A token enters at the tail end on the same step strobe as the word.

On every step, each word is tested against the two tokens it meets: the one in its own slot and the one it crosses on the way to the next slot. The older token is applied first. When a token's match value equals the word, the word is replaced by that token's replacement value.

Every word meets every token in the order the tokens were entered. A chain of substitutions, such as 5 to 6 followed by 6 to 7, therefore resolves fully without any iteration. No single cycle has to broadcast a compare to the whole chain.

Top module: `cfp_counterflow`

## Requirements
- R1: While reset is low, the output word is 0x00, every stored word is 0x00 and every token slot is invalid. After reset, the first DEPTH-1 words to reach the output are 0x00 unless a token rewrites them.
- R2: A cycle with the step strobe low changes nothing. The output word, the stored words and the token slots hold their values. The input word, the token request and the token fields are ignored in that cycle.
- R3: Call the word captured on the m-th step strobe after reset word m. Word m appears on the output right after step m+DEPTH-1 and stays there until the next step. One word leaves per step, in insertion order.
- R4: A valid token rewrites a word it meets only when the word equals the token's match value, and the new value is the token's replacement value. Words that do not match keep their value. Several tokens may name the same replacement value.
- R5: A token entered on step k acts on exactly the words entered on steps k-DEPTH+2 through k+DEPTH. The word already on the output when the token enters, and every word entered after step k+DEPTH, are not changed by it.
- R6: Tokens act on each word in the order they were entered. With the token 0x05 to 0x06 entered before 0x06 to 0x07, a 0x05 in both windows leaves as 0x07. In the opposite order it leaves as 0x06.
- R7: A step with the token request low enters an invalid token. An invalid token never modifies a word, even when its match field equals the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Step strobe: shift both chains by one slot |
| din_i | input | 8 | Word entered at the head on a step |
| chg_req_i | input | 1 | Token request: marks the entering token valid |
| chg_from_i | input | 8 | Match value of the entering token |
| chg_to_i | input | 8 | Replacement value of the entering token |
| dout_o | output | 8 | Word at the tail, removed on the next step |

## Verification
The hardest situations to reach from the ports are the edges of a token's window. These are the last word already inside the chain that the token still reaches and the last word entered later that it still catches. A third case is two adjacent tokens meeting the same word in one step, which is where the ordering rule matters.

The stimulus fills the whole chain with one value, so every word is a candidate. It then enters tokens on consecutive steps and keeps inserting that same value for more than two chain lengths. Each word leaving the chain is compared against the window rule, so both window edges and the two-token overlap are observed directly on the output.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    localparam int unsigned CFP_WORD_W = 8;

    typedef logic [CFP_WORD_W-1:0] cfp_word_t;

    typedef struct packed {
        logic      vld;
        cfp_word_t from_v;
        cfp_word_t to_v;
    } cfp_chg_t;

    localparam cfp_chg_t CFP_CHG_NONE = '0;
endpackage

// File: rtl/cfp_rewrite.sv
// Two ordered substitutions applied to one word: the older token first,
// then the newer one sees the possibly rewritten value.
module cfp_rewrite
    import cfp_pkg::*;
(
    input  cfp_word_t word_i,
    input  cfp_chg_t  older_i,
    input  cfp_chg_t  newer_i,
    output cfp_word_t word_o
);
    cfp_word_t mid;

    always_comb begin
        mid = word_i;
        if (older_i.vld && (older_i.from_v == word_i)) begin
            mid = older_i.to_v;
        end
        word_o = mid;
        if (newer_i.vld && (newer_i.from_v == mid)) begin
            word_o = newer_i.to_v;
        end
    end
endmodule

// File: rtl/cfp_chg_chain.sv
// Token chain: enters at slot DEPTH-1, moves toward slot 0, drops off there.
module cfp_chg_chain
    import cfp_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  cfp_chg_t              tail_i,
    output cfp_chg_t [DEPTH-1:0]  chg_o
);
    localparam int unsigned LAST = DEPTH - 1;

    cfp_chg_t [DEPTH-1:0] chg_q;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        cfp_chg_t nxt;
        if (s == LAST) begin : g_tail
            assign nxt = tail_i;
        end else begin : g_body
            assign nxt = chg_q[s+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chg_q[s] <= CFP_CHG_NONE;
            end else if (step_i) begin
                chg_q[s] <= nxt;
            end
        end
    end

    assign chg_o = chg_q;
endmodule

// File: rtl/cfp_data_chain.sv
// Word chain: enters at slot 0, moves toward slot DEPTH-1. On each step
// a word meets the token in its own slot, then the token it crosses.
module cfp_data_chain
    import cfp_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  cfp_word_t             din_i,
    input  cfp_chg_t  [DEPTH-1:0] chg_i,
    output cfp_word_t [DEPTH-1:0] word_o
);
    cfp_word_t [DEPTH-1:0] word_q;
    cfp_word_t [DEPTH-1:0] word_nxt;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        if (s == 0) begin : g_head
            // The incoming word crosses only the token leaving slot 0.
            cfp_rewrite u_rw (
                .word_i  (din_i),
                .older_i (CFP_CHG_NONE),
                .newer_i (chg_i[0]),
                .word_o  (word_nxt[0])
            );
        end else begin : g_body
            cfp_rewrite u_rw (
                .word_i  (word_q[s-1]),
                .older_i (chg_i[s-1]),
                .newer_i (chg_i[s]),
                .word_o  (word_nxt[s])
            );
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[s] <= '0;
            end else if (step_i) begin
                word_q[s] <= word_nxt[s];
            end
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/cfp_counterflow.sv
module cfp_counterflow
    import cfp_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic [CFP_WORD_W-1:0] din_i,
    input  logic                  chg_req_i,
    input  logic [CFP_WORD_W-1:0] chg_from_i,
    input  logic [CFP_WORD_W-1:0] chg_to_i,
    output logic [CFP_WORD_W-1:0] dout_o
);
    cfp_chg_t              tail_chg;
    cfp_chg_t  [DEPTH-1:0] chg_q;
    cfp_word_t [DEPTH-1:0] word_q;

    always_comb begin
        tail_chg.vld    = chg_req_i;
        tail_chg.from_v = chg_from_i;
        tail_chg.to_v   = chg_to_i;
    end

    cfp_chg_chain #(.DEPTH(DEPTH)) u_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .tail_i (tail_chg),
        .chg_o  (chg_q)
    );

    cfp_data_chain #(.DEPTH(DEPTH)) u_data (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step_i),
        .din_i  (din_i),
        .chg_i  (chg_q),
        .word_o (word_q)
    );

    assign dout_o = word_q[DEPTH-1];
endmodule

// File: rtl/cfp_counterflow_chk.sv
module cfp_counterflow_chk
    import cfp_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  step_i,
    input logic                  chg_req_i,
    input logic [CFP_WORD_W-1:0] dout_o,
    input cfp_word_t [DEPTH-1:0] word_q,
    input cfp_chg_t  [DEPTH-1:0] chg_q
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (dout_o == '0) && !chg_q[DEPTH-1].vld && !chg_q[0].vld);

    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(dout_o) && $stable(chg_q) && $stable(word_q));

    // R3
    a_r3_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !chg_q[DEPTH-1].vld && !chg_q[DEPTH-2].vld)
        |=> dout_o == $past(word_q[DEPTH-2]));

    // R4
    a_r4_match_rewrite: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && chg_q[DEPTH-2].vld && !chg_q[DEPTH-1].vld
         && (word_q[DEPTH-2] == chg_q[DEPTH-2].from_v))
        |=> dout_o == $past(chg_q[DEPTH-2].to_v));

    // R5
    a_r5_token_advance: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> chg_q[0] == $past(chg_q[1]));

    // R7
    a_r7_idle_token: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !chg_req_i) |=> !chg_q[DEPTH-1].vld);
endmodule

bind cfp_counterflow cfp_counterflow_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (step_i),
    .chg_req_i (chg_req_i),
    .dout_o    (dout_o),
    .word_q    (word_q),
    .chg_q     (chg_q)
);

// File: tb/tb_cfp_counterflow.sv
module tb_cfp_counterflow;
    localparam int N   = 8;
    localparam int OFS = 64;
    localparam int HN  = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_i = 1'b0;
    logic [7:0] din_i = '0;
    logic       chg_req_i = 1'b0;
    logic [7:0] chg_from_i = '0;
    logic [7:0] chg_to_i = '0;
    logic [7:0] dout_o;

    int n_chk = 0;
    int n_bad = 0;
    int cur   = 0;

    logic [7:0] hw [HN];
    logic       hv [HN];
    logic [7:0] hf [HN];
    logic [7:0] ht [HN];

    always #2 clk = ~clk;

    cfp_counterflow #(.DEPTH(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step_i),
        .din_i      (din_i),
        .chg_req_i  (chg_req_i),
        .chg_from_i (chg_from_i),
        .chg_to_i   (chg_to_i),
        .dout_o     (dout_o)
    );

    // Word m leaves rewritten by tokens k = m-N .. m+N-2 in entry order.
    function automatic logic [7:0] expect_word(int m);
        logic [7:0] v = hw[m+OFS];
        for (int k = m - N; k <= m + N - 2; k++) begin
            if (k >= 1 && hv[k+OFS] && hf[k+OFS] == v) v = ht[k+OFS];
        end
        return v;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: dout actual=%h expected=%h (step %0d)", tag, act, exp, cur);
        end
    endtask

    task automatic do_step(input logic [7:0] d, input logic req,
                           input logic [7:0] f, input logic [7:0] t, input string tag);
        @(negedge clk);
        step_i = 1'b1; din_i = d; chg_req_i = req; chg_from_i = f; chg_to_i = t;
        @(posedge clk);
        cur++;
        hw[cur+OFS] = d; hv[cur+OFS] = req; hf[cur+OFS] = f; ht[cur+OFS] = t;
        @(negedge clk);
        step_i = 1'b0; chg_req_i = 1'b0;
        check(tag, dout_o, expect_word(cur - N + 1));
    endtask

    task automatic run_plain(input logic [7:0] d, input int cnt, input string tag);
        for (int i = 0; i < cnt; i++) do_step(d, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R1 reset", dout_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", dout_o, 8'h00);
        for (int i = 0; i < N - 1; i++) do_step(8'hE0 + 8'(i), 1'b0, 8'h00, 8'h00, "R1 zero words");
    endtask

    task automatic t_order;
        for (int i = 0; i < 2 * N; i++) do_step(8'h10 + 8'(i), 1'b0, 8'h00, 8'h00, "R3 order");
    endtask

    task automatic t_hold;
        logic [7:0] held = dout_o;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            din_i = 8'h90 + 8'(i); chg_req_i = 1'b1; chg_from_i = 8'h10 + 8'(i); chg_to_i = 8'hCC;
            @(negedge clk);
            check("R2 idle hold", dout_o, held);
        end
        chg_req_i = 1'b0;
        for (int i = 0; i < 2 * N; i++) do_step(8'h10 + 8'(i % 4), 1'b0, 8'h00, 8'h00, "R2 no late effect");
    endtask

    task automatic t_rewrite;
        for (int i = 0; i < N; i++) do_step((i % 2) ? 8'h33 : 8'h44, 1'b0, 8'h00, 8'h00, "R4 fill");
        do_step(8'h33, 1'b1, 8'h33, 8'hA5, "R4 token");
        do_step(8'h55, 1'b0, 8'h00, 8'h00, "R4");
        do_step(8'h44, 1'b1, 8'h44, 8'hA5, "R4 same target");
        for (int i = 0; i < 2 * N; i++) do_step((i % 3 == 0) ? 8'h33 : 8'h44, 1'b0, 8'h00, 8'h00, "R4");
    endtask

    task automatic t_window;
        run_plain(8'h5C, N + 2, "R5 fill");
        do_step(8'h5C, 1'b1, 8'h5C, 8'h11, "R5 token");
        run_plain(8'h5C, 2 * N + 3, "R5 window edges");
    endtask

    task automatic t_order_chain;
        run_plain(8'h05, N + 2, "R6 fill");
        do_step(8'h05, 1'b1, 8'h05, 8'h06, "R6 first");
        do_step(8'h05, 1'b1, 8'h06, 8'h07, "R6 second");
        run_plain(8'h05, 2 * N + 2, "R6 forward chain");
        run_plain(8'h05, N + 2, "R6 refill");
        do_step(8'h05, 1'b1, 8'h06, 8'h07, "R6 rev first");
        do_step(8'h05, 1'b1, 8'h05, 8'h06, "R6 rev second");
        run_plain(8'h05, 2 * N + 2, "R6 reverse chain");
    endtask

    task automatic t_invalid;
        run_plain(8'h77, N + 1, "R7 fill");
        do_step(8'h77, 1'b0, 8'h77, 8'h88, "R7 invalid token");
        do_step(8'h77, 1'b0, 8'h77, 8'h99, "R7 invalid token");
        run_plain(8'h77, 2 * N, "R7 untouched");
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        for (int i = 0; i < HN; i++) begin
            hw[i] = '0; hv[i] = 1'b0; hf[i] = '0; ht[i] = '0;
        end
        t_reset();
        t_order();
        t_hold();
        t_rewrite();
        t_window();
        t_order_chain();
        t_invalid();
        summary();
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end
endmodule